// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management master for Clause 22 PHY register access. A host issues one 32-bit command word through a small synchronous register port. The word names the PHY, the register inside it, the operation, and, for a write, the 16-bit value. The block then clocks a complete management frame out on MDC and MDIO. For a read, it releases MDIO at the turnaround and shifts in the value the PHY returns. When the frame ends, it raises a sticky completion flag.

The same word serves as command and status. The host reads it back to see three things: that a transaction is running, which operation is pending, and whether it has finished. After a read has finished, the upper half of the word holds the captured PHY data. MDC is a divided copy of the system clock. One frame lasts 128 × CLK_DIV system cycles, which is far shorter than the window a host waits before it gives up.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the register reads 0, MDC is low and the MDIO output enable is low.
- R2: A write command drives 64 MDC bits, MSB first, with the output enable high for every bit. The bits are 32 ones, start `01`, opcode `01`, the PHY address from word bits 4:0, the register address from word bits 12:8, turnaround `10`, then the 16 data bits from word bits 31:16.
- R3: A read command drives 32 ones, start `01`, opcode `10`, PHY address and register address. It releases the output enable from bit 46 of the frame (the first turnaround bit) through bit 63. The output enable is never high while the block is idle.
- R4: During a read, the 16 data bits are sampled from the MDIO input on MDC rising edges, MSB first. After completion they read back in word bits 31:16.
- R5: Bit 15 becomes 1 when a frame ends and stays 1. Writing a word with bit 15 set clears it. A word with bit 15 clear and no operation bits changes nothing in the register.
- R6: From the cycle after a command is accepted until the frame ends, bit 5 reads 1 (busy). In the same window, bit 13 reads 1 for a pending write and bit 14 reads 1 for a pending read. Both bits read 0 once the frame has ended.
- R7: Any word written while busy is ignored. The running frame, the stored fields and the completion flag are not affected.
- R8: A word with both bit 13 and bit 14 set is executed as a write.
- R9: MDC has a period of 2 × CLK_DIV system cycles while a frame runs and stays low while idle. The completion flag becomes visible exactly 128 × CLK_DIV cycles after the clock edge that accepts the command.
- R10: Accepting a new command clears the completion flag, even when the word's bit 15 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word written by the host |
| reg_rdata | output | 32 | Command/status word read back |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The table-driven pass alternates reads and writes. It uses different PHY and register addresses and data values such as all ones, all zeros and single-ended bit patterns, so that a swapped field, a reversed bit order or a wrong opcode shows up in the recorded frame. Read entries return values from a modelled PHY. These show whether sampling happens on the correct MDC edge and whether the captured value reaches the upper half of the word. They also show whether the output enable falls exactly at the turnaround rather than one bit early or late. Directed cases then cover the points that separate a careful controller from a naive one:
- a command issued mid-frame, which must not alter the running frame;
- both operation bits set, which must produce a write;
- writes of zero and of the clear bit against a sticky flag;
- a command accepted without the clear bit, which must still drop the flag.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_LEN = 64;
    localparam int TA_IDX    = 46;
    localparam int DATA_IDX  = 48;

    localparam int BIT_BUSY  = 5;
    localparam int BIT_WR    = 13;
    localparam int BIT_RD    = 14;
    localparam int BIT_DONE  = 15;

    // Encoding doubles as the frame opcode.
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
        mdio_cmd_t c;
        if (w[BIT_WR])      c.op = OP_WRITE;   // write wins when both set
        else if (w[BIT_RD]) c.op = OP_READ;
        else                c.op = OP_NONE;
        c.phy   = w[4:0];
        c.regad = w[12:8];
        c.wdata = w[31:16];
        return c;
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  ta;
        logic [15:0] dat;
        ta  = (c.op == OP_WRITE) ? 2'b10 : 2'b11;
        dat = (c.op == OP_WRITE) ? c.wdata : 16'hFFFF;
        return {32'hFFFF_FFFF, 2'b01, c.op, c.phy, c.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term     = (cnt == CW'(CLK_DIV - 1));
    assign rise_stb = en && term && !mdc;
    assign fall_stb = en && term &&  mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: MDC only changes at the end of a half period
    assert_mdc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (en && !term) |=> (mdc == $past(mdc)))
        else $error("MDC toggled mid half-period");

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_in,
    output logic        running,
    output logic        done_pulse,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] rd_data
);
    logic [FRAME_LEN-1:0] frame;
    logic [5:0]           idx;
    mdio_op_e             op_q;
    logic                 last_bit;

    assign last_bit   = (idx == 6'(FRAME_LEN - 1));
    assign done_pulse = running && fall_stb && last_bit;
    assign mdio_out   = running ? frame[FRAME_LEN-1] : 1'b0;
    assign mdio_oe    = running && !(op_q == OP_READ && idx >= 6'(TA_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            idx     <= '0;
            frame   <= '0;
            op_q    <= OP_NONE;
            rd_data <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            idx     <= '0;
            frame   <= build_frame(cmd);
            op_q    <= cmd.op;
        end else if (running) begin
            if (rise_stb && op_q == OP_READ && idx >= 6'(DATA_IDX))
                rd_data <= {rd_data[14:0], mdio_in};
            if (fall_stb) begin
                if (last_bit) begin
                    running <= 1'b0;
                end else begin
                    idx   <= idx + 1'b1;
                    frame <= {frame[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    // R6: the frame end returns the block to idle
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !running)
        else $error("still running after frame end");

endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        busy,
    input  logic        done_pulse,
    input  logic [15:0] rd_data,
    output logic        start,
    output mdio_cmd_t   cmd,
    output logic [31:0] rdata
);
    logic [4:0]  phy_q;
    logic [4:0]  reg_q;
    logic [15:0] data_q;
    mdio_op_e    op_q;
    logic        done_q;
    logic        unused_bits;

    assign unused_bits = ^wdata[7:5];
    assign cmd   = decode_cmd(wdata);
    assign start = wr && !busy && (cmd.op != OP_NONE);

    assign rdata = {data_q, done_q, op_q == OP_READ, op_q == OP_WRITE,
                    reg_q, 2'b00, busy, phy_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
            op_q   <= OP_NONE;
            done_q <= 1'b0;
        end else if (done_pulse) begin
            done_q <= 1'b1;
            op_q   <= OP_NONE;
            if (op_q == OP_READ) data_q <= rd_data;
        end else if (wr && !busy) begin
            if (wdata[BIT_DONE]) done_q <= 1'b0;
            if (start) begin
                done_q <= 1'b0;
                phy_q  <= cmd.phy;
                reg_q  <= cmd.regad;
                op_q   <= cmd.op;
                if (cmd.op == OP_WRITE) data_q <= cmd.wdata;
            end
        end
    end

    // R5: the flag survives every cycle without a host write
    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (done_q && !wr) |=> done_q)
        else $error("completion flag dropped");

    // R7: stored fields frozen while busy
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(phy_q) && $stable(reg_q)))
        else $error("fields changed while busy");

    // R8: both operation bits give a write
    assert_both_write_R8: assert property (@(posedge clk) disable iff (rst)
        (start && wdata[BIT_WR] && wdata[BIT_RD]) |=> (op_q == OP_WRITE))
        else $error("dual-op word not a write");

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic        busy;
    logic        start;
    logic        done_pulse;
    logic        rise_stb;
    logic        fall_stb;
    logic [15:0] rd_data;
    mdio_cmd_t   cmd;

    mdio_cmd_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rd_data    (rd_data),
        .start      (start),
        .cmd        (cmd),
        .rdata      (reg_rdata)
    );

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .en       (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cmd        (cmd),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .mdio_in    (mdio_in),
        .running    (busy),
        .done_pulse (done_pulse),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe),
        .rd_data    (rd_data)
    );

    // R9: MDC parked low whenever the block is idle
    assert_mdc_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc)
        else $error("MDC active while idle");

    // R3: the line is only driven while a frame runs
    assert_oe_busy_R3: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> reg_rdata[BIT_BUSY])
        else $error("MDIO driven while idle");

endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;
    localparam int DIV = 4;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] val;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 5'd1,  5'd0,  16'h1140},
        '{1'b1, 5'd31, 5'd31, 16'hA5C3},
        '{1'b0, 5'd0,  5'd16, 16'hFFFF},
        '{1'b1, 5'd5,  5'd2,  16'h8001},
        '{1'b0, 5'd18, 5'd9,  16'h0000},
        '{1'b1, 5'd10, 5'd21, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int          tests = 0;
    int          fails = 0;
    int          mon_cnt = 0;
    logic [63:0] mon_bits = '0;
    logic [63:0] mon_oe = '0;
    logic [15:0] phy_val = '0;
    logic [31:0] snap;

    always #2.5 clk = ~clk;

    mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // frame recorder: one entry per MDC rising edge
    always @(posedge mdc) begin
        if (mon_cnt < 64) begin
            mon_bits[63-mon_cnt] = mdio_out;
            mon_oe[63-mon_cnt]   = mdio_oe;
        end
        mon_cnt = mon_cnt + 1;
    end

    // PHY model: presents read data after MDC falls
    always @(negedge mdc) begin
        if (mon_cnt >= 48 && mon_cnt < 64) mdio_in = phy_val[63-mon_cnt];
        else                               mdio_in = 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        @(negedge clk);
        snap = reg_rdata;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!reg_rdata[15] && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
        if (rd) return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
        return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_mask(input logic rd);
        return rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R9 act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [31:0] w;
        logic [63:0] ef, em;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", 64'(reg_rdata), 64'h0);
        chk("R1 reset mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

        // table pass
        for (int i = 0; i < 6; i++) begin
            vec_t v = VECS[i];
            phy_val = v.val;
            mon_cnt = 0;
            w = {v.rd ? 16'h0 : v.val, 1'b1, v.rd, !v.rd, v.ra, 3'b000, v.phy};
            issue(w);
            chk("R6 busy/pending bits", 64'({snap[14:13], snap[5]}), 64'({v.rd, !v.rd, 1'b1}));
            wait_done(n);
            chk("R9 frame duration", 64'(n), 64'(128*DIV));
            ef = exp_frame(v.rd, v.phy, v.ra, v.val);
            em = exp_mask(v.rd);
            chk(v.rd ? "R3 read frame bits" : "R2 write frame bits", mon_bits & em, ef);
            chk(v.rd ? "R3 read output enable" : "R2 write output enable", mon_oe, em);
            chk(v.rd ? "R4 read data word" : "R5 done word", 64'(reg_rdata),
                64'({v.val, 1'b1, 2'b00, v.ra, 3'b000, v.phy}));
            chk("R9 mdc idle, 64 bits", {mdc, 31'h0, 32'(mon_cnt)}, 64'd64);
        end

        // R8 + R10: both op bits, no clear bit while flag is set
        mon_cnt = 0;
        issue({16'h5A5A, 1'b0, 2'b11, 5'd3, 3'b000, 5'd6});
        chk("R10 accept clears flag", 64'({snap[15], snap[13]}), 64'b01);
        wait_done(n);
        chk("R8 dual op frame", mon_bits, exp_frame(1'b0, 5'd6, 5'd3, 16'h5A5A));
        chk("R8 dual op enable", mon_oe, {64{1'b1}});

        // R7: command during a running frame
        mon_cnt = 0;
        issue({16'h1234, 1'b1, 2'b01, 5'd4, 3'b000, 5'd3});
        repeat (40) @(negedge clk);
        issue({16'hBEEF, 1'b1, 2'b10, 5'd7, 3'b000, 5'd9});
        chk("R7 busy write ignored", 64'({snap[14:13], snap[5]}), 64'b011);
        wait_done(n);
        chk("R7 frame unchanged", mon_bits, exp_frame(1'b0, 5'd3, 5'd4, 16'h1234));
        chk("R7 word unchanged", 64'(reg_rdata), 64'({16'h1234, 1'b1, 2'b00, 5'd4, 3'b000, 5'd3}));

        // R5: zero write does nothing, clear bit clears the flag
        issue(32'h0000_0000);
        repeat (10) @(negedge clk);
        chk("R5 zero write no effect", {31'h0, mdc, reg_rdata},
            64'({16'h1234, 1'b1, 2'b00, 5'd4, 3'b000, 5'd3}));
        issue(32'h0000_8000);
        chk("R5 write-1 clears flag", 64'(reg_rdata),
            64'({16'h1234, 1'b0, 2'b00, 5'd4, 3'b000, 5'd3}));
        chk("R3 idle output enable", 64'(mdio_oe), 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule